// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a single-cycle datapath stage that moves the bits of an 8, 16 or 32-bit operand left or right by a variable count and returns the moved value together with an updated carry flag. Eight operation codes select zero-filling shifts in both directions, a sign-filling right shift, plain rotates in both directions, and rotates that pass through the carry flag as an extra bit of the value. The carry flag is part of every operation: it holds the last bit moved out, or it is the extra bit in the through-carry rotates.

The caller presents an operation code, a size code, the operand, a count and the present carry flag on one clock edge. The result and the new carry appear registered after that edge. Operand bits above the chosen size are ignored, and result bits above it are zero. Overflow flags, memory operands and instruction decoding belong to other blocks.

Top module: `sr_shift_rotate`

## Requirements
- R1: Codes 0 and 7 shift left and fill with zeros. The carry takes the last bit shifted out: operand bit (W - n) for n <= W, or 0 when n > W. W is the chosen width and n is the masked count.
- R2: Code 1 shifts right and fills with zeros. Code 2 shifts right and fills with the sign bit, which is bit W-1 of the operand. The carry takes operand bit n-1. When n > W it takes 0 for code 1 and the sign bit for code 2.
- R3: Only the low 5 bits of the count are used. A masked count of zero gives result = operand (limited to the width) and carry = carry in, for every code.
- R4: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width have no effect, and result bits above it are zero.
- R5: Code 3 rotates left by n mod W. When n is nonzero, the carry equals bit 0 of the result.
- R6: Code 4 rotates right by n mod W. When n is nonzero, the carry equals bit W-1 of the result.
- R7: Code 5 rotates the (W+1)-bit value {carry, operand} left by n mod (W+1). The result takes the low W bits and the carry takes the top bit.
- R8: Code 6 rotates the same (W+1)-bit value right by n mod (W+1), with the same split into result and carry.
- R9: The result and carry are registered. They change only on the clock edge that samples the inputs, and an active-low reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (see R1, R2, R5 to R8) |
| size_i | input | 2 | Operand width code (see R4) |
| operand_i | input | 32 | Value to shift or rotate |
| count_i | input | 8 | Shift count; only bits 4:0 are used |
| carry_i | input | 1 | Present carry flag |
| result_o | output | 32 | Registered result, zero above the width |
| carry_o | output | 1 | Registered updated carry flag |

## Verification
Fixed vectors use worked byte rotations with known answers. They also use single-bit and sign-bit operands whose carry can only come from one position, which separates the last-bit-out rule from an off-by-one neighbour and separates zero fill from sign fill. Counts equal to, just above and far above the width, together with counts of 9, 17 and 32, tell the plain rotate modulus apart from the through-carry modulus and from the 5-bit count mask. A sweep over every code, every size and all 32 masked counts runs with varying operands, garbage in the upper operand and count bits, and alternating carry in. Its results are compared with a one-bit-per-step model, which catches width leaks and carry-selection errors that the fixed vectors miss.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int unsigned DW = 32;              // widest operand
    localparam int unsigned CW = 8;               // count input width
    localparam int unsigned MW = 5;               // used count bits
    localparam int unsigned WW = $clog2(DW) + 1;  // holds a width value up to DW+1
    localparam int unsigned RED_STEPS = (1 << MW) / 8;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_SAL = 3'd7
    } sr_op_e;

    typedef struct packed {
        logic [DW-1:0] result;
        logic          carry;
    } sr_out_t;

    // count modulo n, for n >= 8 and count < 2**MW
    function automatic logic [MW-1:0] reduce_count(input logic [MW-1:0] c,
                                                   input logic [WW-1:0] n);
        logic [WW-1:0] r;
        r = WW'(c);
        for (int i = 0; i < int'(RED_STEPS); i++) begin
            if (r >= n) r = r - n;
        end
        return r[MW-1:0];
    endfunction

endpackage

// File: rtl/sr_width_sel.sv
module sr_width_sel #(
    parameter int unsigned DW = sr_pkg::DW,
    parameter int unsigned WW = sr_pkg::WW
) (
    input  logic [1:0]    size_i,
    output logic [WW-1:0] width_o,
    output logic [DW-1:0] mask_o
);
    always_comb begin
        case (size_i)
            2'd0: begin
                width_o = WW'(8);
                mask_o  = DW'(8'hFF);
            end
            2'd1: begin
                width_o = WW'(16);
                mask_o  = DW'(16'hFFFF);
            end
            default: begin
                width_o = WW'(DW);
                mask_o  = '1;
            end
        endcase
    end
endmodule

// File: rtl/sr_shift_core.sv
module sr_shift_core #(
    parameter int unsigned DW = sr_pkg::DW,
    parameter int unsigned WW = sr_pkg::WW,
    parameter int unsigned MW = sr_pkg::MW
) (
    input  logic [DW-1:0] val_i,     // already limited to the width
    input  logic [DW-1:0] mask_i,
    input  logic [WW-1:0] width_i,
    input  logic [MW-1:0] cnt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [DW-1:0] res_o,
    output logic          carry_o
);
    localparam int unsigned XW = 2 * DW;

    logic [DW-1:0] top_bit;
    logic          fill;
    logic [DW-1:0] sval;
    logic [XW-1:0] lx;
    logic [XW-1:0] lx_at_w;
    logic [XW:0]   rx;

    always_comb begin
        top_bit = mask_i ^ (mask_i >> 1);
        fill    = arith_i & (|(val_i & top_bit));
        // left: bits leaving the width land at position width and above
        lx      = {{DW{1'b0}}, val_i} << cnt_i;
        lx_at_w = lx >> width_i;
        // right: one guard bit below bit 0 catches the last bit out
        sval    = val_i | (fill ? ~mask_i : '0);
        rx      = {{DW{fill}}, sval, 1'b0} >> cnt_i;
        if (left_i) begin
            res_o   = lx[DW-1:0] & mask_i;
            carry_o = lx_at_w[0];
        end else begin
            res_o   = rx[DW:1] & mask_i;
            carry_o = rx[0];
        end
    end
endmodule

// File: rtl/sr_rot_core.sv
module sr_rot_core #(
    parameter int unsigned DW = sr_pkg::DW,
    parameter int unsigned WW = sr_pkg::WW,
    parameter int unsigned MW = sr_pkg::MW
) (
    input  logic [DW-1:0] val_i,
    input  logic [DW-1:0] mask_i,
    input  logic [WW-1:0] width_i,
    input  logic [MW-1:0] cnt_i,
    input  logic          carry_i,
    input  logic          left_i,
    input  logic          thru_i,
    output logic [DW-1:0] res_o,
    output logic          carry_o
);
    import sr_pkg::reduce_count;

    localparam int unsigned XW = 2 * DW;

    logic [WW-1:0] ring;      // bits taking part in the rotation
    logic [MW-1:0] k_eff;
    logic [WW-1:0] lamt;      // equivalent left amount
    logic [XW-1:0] q;
    logic [XW-1:0] ring_mask;
    logic [XW-1:0] rq;
    logic [XW-1:0] rq_at_w;
    logic [DW-1:0] top_bit;

    always_comb begin
        ring      = thru_i ? width_i + WW'(1) : width_i;
        k_eff     = reduce_count(cnt_i, ring);
        if (left_i || k_eff == '0) lamt = WW'(k_eff);
        else                       lamt = ring - WW'(k_eff);
        q         = XW'(val_i) | (XW'(thru_i & carry_i) << width_i);
        ring_mask = (XW'(1) << ring) - XW'(1);
        rq        = ((q << lamt) | (q >> (ring - lamt))) & ring_mask;
        rq_at_w   = rq >> width_i;
        top_bit   = mask_i ^ (mask_i >> 1);
        res_o     = rq[DW-1:0] & mask_i;
        if (thru_i)      carry_o = rq_at_w[0];
        else if (left_i) carry_o = rq[0];
        else             carry_o = |(rq[DW-1:0] & top_bit);
    end
endmodule

// File: rtl/sr_shift_rotate.sv
module sr_shift_rotate #(
    parameter int unsigned DW = sr_pkg::DW,
    parameter int unsigned CW = sr_pkg::CW,
    parameter int unsigned MW = sr_pkg::MW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] operand_i,
    input  logic [CW-1:0] count_i,
    input  logic          carry_i,
    output logic [DW-1:0] result_o,
    output logic          carry_o
);
    import sr_pkg::*;

    localparam int unsigned WW = $clog2(DW) + 1;

    sr_op_e        op;
    logic [WW-1:0] width_w;
    logic [DW-1:0] mask_w;
    logic [DW-1:0] val_m;
    logic [MW-1:0] cnt_m;
    logic          is_shift;
    logic          sh_left;
    logic          sh_arith;
    logic          rt_left;
    logic          rt_thru;
    logic [DW-1:0] sh_res;
    logic          sh_carry;
    logic [DW-1:0] rt_res;
    logic          rt_carry;
    sr_out_t       st_d;
    sr_out_t       st_q;

    assign op       = sr_op_e'(op_i);
    assign cnt_m    = count_i[MW-1:0];
    assign val_m    = operand_i & mask_w;
    assign is_shift = (op == OP_SHL) || (op == OP_SAL) || (op == OP_SHR) || (op == OP_SAR);
    assign sh_left  = (op == OP_SHL) || (op == OP_SAL);
    assign sh_arith = (op == OP_SAR);
    assign rt_left  = (op == OP_ROL) || (op == OP_RCL);
    assign rt_thru  = (op == OP_RCL) || (op == OP_RCR);

    sr_width_sel #(.DW(DW), .WW(WW)) i_width (
        .size_i  (size_i),
        .width_o (width_w),
        .mask_o  (mask_w)
    );

    sr_shift_core #(.DW(DW), .WW(WW), .MW(MW)) i_shift (
        .val_i   (val_m),
        .mask_i  (mask_w),
        .width_i (width_w),
        .cnt_i   (cnt_m),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .res_o   (sh_res),
        .carry_o (sh_carry)
    );

    sr_rot_core #(.DW(DW), .WW(WW), .MW(MW)) i_rot (
        .val_i   (val_m),
        .mask_i  (mask_w),
        .width_i (width_w),
        .cnt_i   (cnt_m),
        .carry_i (carry_i),
        .left_i  (rt_left),
        .thru_i  (rt_thru),
        .res_o   (rt_res),
        .carry_o (rt_carry)
    );

    always_comb begin
        st_d.result = val_m;
        st_d.carry  = carry_i;
        if (cnt_m != '0) begin
            if (is_shift) begin
                st_d.result = sh_res;
                st_d.carry  = sh_carry;
            end else begin
                st_d.result = rt_res;
                st_d.carry  = rt_carry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign carry_o  = st_q.carry;

    a_r3_zero_count_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_m) == '0)
        |-> (result_o == $past(val_m)) && (carry_o == $past(carry_i)));

    a_r4_no_bits_above_width: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (result_o & ~$past(mask_w)) == '0);

    a_r5_rol_carry_is_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_ROL && $past(cnt_m) != '0)
        |-> carry_o == result_o[0]);

    a_r6_ror_carry_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_ROR && $past(cnt_m) != '0)
        |-> carry_o == (|(result_o & $past(mask_w ^ (mask_w >> 1)))));

    a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == OP_ROL || $past(op) == OP_ROR))
        |-> $countones(result_o) == $countones($past(val_m)));

    a_r7_thru_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op) == OP_RCL || $past(op) == OP_RCR))
        |-> $countones({carry_o, result_o}) == $countones({$past(carry_i), $past(val_m)}));

endmodule

// File: tb/test_sr_shift_rotate.sv
module test_sr_shift_rotate;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [7:0]  cnt;
        logic        cf;
        logic [31:0] v;
        logic [31:0] er;
        logic        ec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 2'd0, 8'd2,    1'b0, 32'h0000_0043, 32'h0000_00D0, 1'b1, 4'd6}, // R6
        '{3'd3, 2'd0, 8'd4,    1'b1, 32'h0000_00D0, 32'h0000_000D, 1'b1, 4'd5}, // R5
        '{3'd6, 2'd0, 8'd3,    1'b1, 32'h0000_000D, 32'h0000_0061, 1'b1, 4'd8}, // R8
        '{3'd5, 2'd0, 8'd4,    1'b1, 32'h0000_0061, 32'h0000_001B, 1'b0, 4'd7}, // R7
        '{3'd0, 2'd0, 8'd1,    1'b0, 32'h0000_0081, 32'h0000_0002, 1'b1, 4'd1}, // R1
        '{3'd7, 2'd1, 8'd4,    1'b0, 32'h0000_F00F, 32'h0000_00F0, 1'b1, 4'd1}, // R1
        '{3'd0, 2'd0, 8'd9,    1'b1, 32'h0000_00FF, 32'h0000_0000, 1'b0, 4'd1}, // R1
        '{3'd1, 2'd0, 8'd3,    1'b0, 32'h0000_0085, 32'h0000_0010, 1'b1, 4'd2}, // R2
        '{3'd2, 2'd0, 8'd3,    1'b0, 32'h0000_0085, 32'h0000_00F0, 1'b1, 4'd2}, // R2
        '{3'd2, 2'd1, 8'd20,   1'b0, 32'h0000_8000, 32'h0000_FFFF, 1'b1, 4'd2}, // R2
        '{3'd2, 2'd2, 8'd31,   1'b0, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 4'd2}, // R2
        '{3'd1, 2'd2, 8'd31,   1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'd2}, // R2
        '{3'd3, 2'd0, 8'h20,   1'b1, 32'h1234_56AB, 32'h0000_00AB, 1'b1, 4'd3}, // R3
        '{3'd0, 2'd0, 8'h21,   1'b0, 32'h0000_0040, 32'h0000_0080, 1'b0, 4'd3}, // R3
        '{3'd3, 2'd1, 8'd16,   1'b0, 32'h0000_1235, 32'h0000_1235, 1'b1, 4'd5}, // R5
        '{3'd4, 2'd2, 8'd8,    1'b0, 32'h1234_5678, 32'h7812_3456, 1'b0, 4'd6}, // R6
        '{3'd5, 2'd0, 8'd9,    1'b1, 32'h0000_005A, 32'h0000_005A, 1'b1, 4'd7}, // R7
        '{3'd6, 2'd1, 8'd1,    1'b1, 32'h0000_0001, 32'h0000_8000, 1'b1, 4'd8}, // R8
        '{3'd5, 2'd2, 8'd1,    1'b0, 32'h8000_0000, 32'h0000_0000, 1'b1, 4'd7}, // R7
        '{3'd0, 2'd3, 8'd4,    1'b0, 32'h1000_0000, 32'h0000_0000, 1'b1, 4'd4}, // R4
        '{3'd1, 2'd1, 8'd4,    1'b0, 32'hFFFF_0010, 32'h0000_0001, 1'b0, 4'd4}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] operand_i = '0;
    logic [7:0]  count_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sr_shift_rotate i_sr_shift_rotate (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .size_i    (size_i),
        .operand_i (operand_i),
        .count_i   (count_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    function automatic string op_req(input logic [2:0] o);
        case (o)
            3'd0, 3'd7: return "R1";
            3'd1, 3'd2: return "R2";
            3'd3:       return "R5";
            3'd4:       return "R6";
            3'd5:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    // one bit per step reference
    function automatic logic [32:0] model(input logic [2:0] o, input logic [1:0] sz,
                                          input logic [7:0] cnt, input logic cf,
                                          input logic [31:0] v);
        int w;
        logic [63:0] x;
        logic [63:0] msk;
        logic c;
        logic t;
        logic s;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        msk = (64'd1 << w) - 64'd1;
        x = {32'd0, v} & msk;
        c = cf;
        for (int i = 0; i < int'(cnt[4:0]); i++) begin
            case (o)
                3'd0, 3'd7: begin c = x[w-1]; x = (x << 1) & msk; end
                3'd1: begin c = x[0]; x = x >> 1; end
                3'd2: begin c = x[0]; s = x[w-1]; x = (x >> 1) | (64'(s) << (w-1)); end
                3'd3: begin c = x[w-1]; x = ((x << 1) | 64'(c)) & msk; end
                3'd4: begin c = x[0]; x = (x >> 1) | (64'(c) << (w-1)); end
                3'd5: begin t = x[w-1]; x = ((x << 1) | 64'(c)) & msk; c = t; end
                default: begin t = x[0]; x = (x >> 1) | (64'(c) << (w-1)); c = t; end
            endcase
        end
        return {c, x[31:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic ec);
        n_checks++;
        if (result_o !== er || carry_o !== ec) begin
            n_fail++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     req, result_o, carry_o, er, ec);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [1:0] sz, input logic [7:0] cnt,
                         input logic cf, input logic [31:0] v);
        op_i = o; size_i = sz; count_i = cnt; carry_i = cf; operand_i = v;
    endtask

    task automatic run(input logic [2:0] o, input logic [1:0] sz, input logic [7:0] cnt,
                       input logic cf, input logic [31:0] v,
                       input logic [31:0] er, input logic ec, input string req);
        @(negedge clk);
        drive(o, sz, cnt, cf, v);
        @(negedge clk);
        check(req, er, ec);
    endtask

    initial begin
        logic [32:0] m;
        // R9: reset state with busy inputs
        drive(3'd0, 2'd2, 8'd1, 1'b1, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R9", 32'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 32'hFFFF_FFFE, 1'b1);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, VECS[i].sz, VECS[i].cnt, VECS[i].cf, VECS[i].v,
                VECS[i].er, VECS[i].ec, $sformatf("R%0d", VECS[i].req));
        end

        // R9: new inputs do not reach the outputs before the next edge
        @(negedge clk);
        drive(3'd4, 2'd0, 8'd2, 1'b0, 32'h43);
        @(negedge clk);
        drive(3'd3, 2'd0, 8'd4, 1'b1, 32'hD0);
        #1;
        check("R9", 32'hD0, 1'b1);
        @(negedge clk);
        check("R9", 32'h0D, 1'b1);

        // R9: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", 32'd0, 1'b0);
        rst_n = 1'b1;

        // sweep every code, size and masked count (R3, R4 via upper garbage)
        for (int o = 0; o < 8; o++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int c = 0; c < 32; c++) begin
                    logic [31:0] v;
                    logic [7:0]  cnt;
                    logic        cf;
                    v   = 32'hA5C3_1E69 ^ (32'(c) * 32'h0101_0101) ^ (32'(o) << 13) ^ (32'(sz) << 27);
                    cnt = {3'(o + sz), 5'(c)};
                    cf  = c[0] ^ o[0];
                    m   = model(3'(o), 2'(sz), cnt, cf, v);
                    run(3'(o), 2'(sz), cnt, cf, v, m[31:0], m[32],
                        (c == 0) ? "R3" : op_req(3'(o)));
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule